// File: doc/BRIEF.md
# Fluorescent Display Grid and Key Scan Timer

This block is the timing core of a multiplexed vacuum fluorescent display controller. It steps through a programmable number of grids, from 8 to 16, and gives each grid a time slot. In each slot it reads one 20-bit word from an external display memory and drives that word onto the segment lines while only that slot's grid is enabled. Each slot begins with a short blanking gap. After the gap, the grid stays lit for a brightness-dependent number of cycles that is set in eight steps. A display-off input blanks every display output.

After the last grid slot, the block starts a key-scan phase. The twelve low segment lines then act as key-scan sources and are raised one at a time. The four key return lines are sampled into a 48-bit key map. The 4-bit switch port is latched in the final cycle of every full cycle of display slots plus key scan, called a frame. Eight output pins are shared between segment and grid use. The duty setting decides which of these pins carry segment data and which carry grid enables.

The host interface that writes the display memory is outside this block, and so are the high-voltage output stages.

Top module: `vfd_scan_timer`

## Requirements
- R1: While `rst` is high, `seg_lo`, `grid_lo`, `shared`, `key_data`, `sw_latch` and `mem_raddr` are all zero.
- R2: The active grid count is 8 + `duty_code` for codes 0 to 8, and 16 for any code above 8. Each frame has that many display slots of GAP_TICKS + 8*DIM_STEP cycles each, followed by 12 key steps of KEY_TICKS cycles each.
- R3: In the lit part of slot g (0-based), exactly one grid is on, and `seg_lo[11:0]` equals bits 11:0 of memory word g. Grids 0 to 7 appear on `grid_lo[g]`.
- R4: Shared pin j (0 to 7) is paired with 0-based grid 15-j, so pin 0 pairs with the highest grid. If 15-j is below the active grid count, the pin is a grid enable for that grid. Otherwise it carries bit 12+j of the current word.
- R5: The first GAP_TICKS cycles of every display slot drive all segment, grid and shared outputs low.
- R6: After the gap, outputs stay lit for (`dim_lvl`+1)*DIM_STEP cycles, where `dim_lvl` is 3 bits. They are blanked for the rest of the slot.
- R7: While `disp_on` is low, the segment, grid and shared outputs are low throughout the display slots. The key-scan phase still runs.
- R8: In key step s (0 to 11), only `seg_lo[s]` is high, and `grid_lo` and `shared` are zero.
- R9: `key_data[4*s + r]` holds `key_ret[r]` as sampled in the last cycle of key step s. The key map updates once per frame.
- R10: `sw_latch` takes `sw_in` in the last cycle of each frame and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_code | input | 4 | Grid count select: 8 + code, limited to 16 |
| dim_lvl | input | 3 | Brightness step, 0 dimmest to 7 brightest |
| disp_on | input | 1 | Display enable; low blanks display outputs |
| mem_raddr | output | 4 | Display memory read address, equal to the current grid |
| mem_rdata | input | 20 | Display memory word, one cycle after the address |
| key_ret | input | 4 | Key matrix return lines |
| sw_in | input | 4 | General-purpose switch inputs |
| seg_lo | output | 12 | Segment lines 1 to 12, also the key-scan sources |
| grid_lo | output | 8 | Dedicated grid lines 1 to 8 |
| shared | output | 8 | Pins that act as segment 13+j or grid 16-j |
| key_data | output | 48 | Key map, four return bits per source |
| sw_latch | output | 4 | Switch port latched once per frame |

## Verification
The bench predicts every output cycle by cycle over whole frames and compares against it. Runs cover the smallest duty, the largest duty, a code above 8 that must be limited to 16, and middle duties where only part of the shared pins become grids. This separates errors in shared-pin pairing from errors in segment data. Brightness steps 0, 3 and 7 place the blanking edge at different ticks within the slot, so mistakes in the gap and in the lit window show up separately. A display-off run confirms that the display is blank while key scanning still runs. A key matrix modelled from the driven source lines, together with a switch change in mid-frame, checks both the key map positions and the once-per-frame switch capture.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
  localparam int SEG_LO_N  = 12;
  localparam int GRID_LO_N = 8;
  localparam int SHARED_N  = 8;
  localparam int MAX_GRIDS = GRID_LO_N + SHARED_N;
  localparam int WORD_W    = SEG_LO_N + SHARED_N;
  localparam int RET_N     = 4;
  localparam int SW_N      = 4;
  localparam int ADDR_W    = $clog2(MAX_GRIDS);
  localparam int NG_W      = ADDR_W + 1;

  typedef enum logic {PH_DISP = 1'b0, PH_KEY = 1'b1} scan_phase_e;

  function automatic logic [NG_W-1:0] grids_of(input logic [3:0] code);
    if (code > 4'd8) return NG_W'(MAX_GRIDS);
    return NG_W'(GRID_LO_N) + NG_W'(code);
  endfunction
endpackage

// File: rtl/vfd_scan_seq.sv
module vfd_scan_seq
  import vfd_scan_pkg::*;
#(
  parameter int GAP_TICKS = 2,
  parameter int DIM_STEP  = 2,
  parameter int KEY_TICKS = 4,
  localparam int SLOT_LEN = GAP_TICKS + 8 * DIM_STEP,
  localparam int TMAX     = (SLOT_LEN > KEY_TICKS) ? SLOT_LEN : KEY_TICKS,
  localparam int TW       = $clog2(TMAX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        duty_code,
  output scan_phase_e       phase,
  output logic [ADDR_W-1:0] idx,
  output logic [TW-1:0]     tick,
  output logic [NG_W-1:0]   ngrids,
  output logic              frame_end
);
  logic slot_last, step_last, grid_last, src_last;

  assign slot_last = (tick == TW'(SLOT_LEN - 1));
  assign step_last = (tick == TW'(KEY_TICKS - 1));
  assign grid_last = ({1'b0, idx} == ngrids - NG_W'(1));
  assign src_last  = (idx == ADDR_W'(SEG_LO_N - 1));
  assign frame_end = (phase == PH_KEY) && src_last && step_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_DISP;
      idx    <= '0;
      tick   <= '0;
      ngrids <= grids_of(duty_code);
    end else if (phase == PH_DISP) begin
      if (slot_last) begin
        tick <= '0;
        if (grid_last) begin
          phase <= PH_KEY;
          idx   <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end else begin
      if (step_last) begin
        tick <= '0;
        if (src_last) begin
          phase  <= PH_DISP;
          idx    <= '0;
          ngrids <= grids_of(duty_code);
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vfd_scan_drive.sv
module vfd_scan_drive
  import vfd_scan_pkg::*;
#(
  parameter int GAP_TICKS = 2,
  parameter int DIM_STEP  = 2,
  parameter int TW        = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  scan_phase_e          phase,
  input  logic [ADDR_W-1:0]    idx,
  input  logic [TW-1:0]        tick,
  input  logic [NG_W-1:0]      ngrids,
  input  logic [2:0]           dim_lvl,
  input  logic                 disp_on,
  input  logic [WORD_W-1:0]    word,
  output logic [SEG_LO_N-1:0]  seg_lo,
  output logic [GRID_LO_N-1:0] grid_lo,
  output logic [SHARED_N-1:0]  shared
);
  logic [SEG_LO_N-1:0]  seg_n;
  logic [GRID_LO_N-1:0] grid_n;
  logic [SHARED_N-1:0]  sh_n;
  logic                 lit;
  int                   lit_end;

  always_comb begin
    lit_end = GAP_TICKS + (int'(dim_lvl) + 1) * DIM_STEP;
    lit     = (int'(tick) >= GAP_TICKS) && (int'(tick) < lit_end);
    seg_n   = '0;
    grid_n  = '0;
    sh_n    = '0;
    if (phase == PH_KEY) begin
      for (int s = 0; s < SEG_LO_N; s++)
        if (int'(idx) == s) seg_n[s] = 1'b1;
    end else if (disp_on && lit) begin
      seg_n = word[SEG_LO_N-1:0];
      for (int j = 0; j < SHARED_N; j++) begin
        if ((MAX_GRIDS - 1 - j) >= int'(ngrids)) sh_n[j] = word[SEG_LO_N + j];
        if (int'(idx) == MAX_GRIDS - 1 - j) sh_n[j] = 1'b1;
      end
      for (int g = 0; g < GRID_LO_N; g++)
        if (int'(idx) == g) grid_n[g] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_lo  <= '0;
      grid_lo <= '0;
      shared  <= '0;
    end else begin
      seg_lo  <= seg_n;
      grid_lo <= grid_n;
      shared  <= sh_n;
    end
  end
endmodule

// File: rtl/vfd_key_sampler.sv
module vfd_key_sampler
  import vfd_scan_pkg::*;
#(
  parameter int KEY_TICKS = 4,
  parameter int TW        = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  scan_phase_e                 phase,
  input  logic [ADDR_W-1:0]           idx,
  input  logic [TW-1:0]               tick,
  input  logic                        frame_end,
  input  logic [RET_N-1:0]            key_ret,
  input  logic [SW_N-1:0]             sw_in,
  output logic [SEG_LO_N*RET_N-1:0]   key_data,
  output logic [SW_N-1:0]             sw_latch
);
  logic step_last;
  assign step_last = (phase == PH_KEY) && (tick == TW'(KEY_TICKS - 1));

  for (genvar s = 0; s < SEG_LO_N; s++) begin : g_src
    logic [RET_N-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (rst) cell_q <= '0;
      else if (step_last && idx == ADDR_W'(s)) cell_q <= key_ret;
    end
    assign key_data[s*RET_N +: RET_N] = cell_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sw_latch <= '0;
    else if (frame_end) sw_latch <= sw_in;
  end
endmodule

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer
  import vfd_scan_pkg::*;
#(
  parameter int GAP_TICKS = 2,
  parameter int DIM_STEP  = 2,
  parameter int KEY_TICKS = 4,
  localparam int SLOT_LEN = GAP_TICKS + 8 * DIM_STEP,
  localparam int TMAX     = (SLOT_LEN > KEY_TICKS) ? SLOT_LEN : KEY_TICKS,
  localparam int TW       = $clog2(TMAX)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  duty_code,
  input  logic [2:0]  dim_lvl,
  input  logic        disp_on,
  output logic [3:0]  mem_raddr,
  input  logic [19:0] mem_rdata,
  input  logic [3:0]  key_ret,
  input  logic [3:0]  sw_in,
  output logic [11:0] seg_lo,
  output logic [7:0]  grid_lo,
  output logic [7:0]  shared,
  output logic [47:0] key_data,
  output logic [3:0]  sw_latch
);
  scan_phase_e       phase;
  logic [ADDR_W-1:0] idx;
  logic [TW-1:0]     tick;
  logic [NG_W-1:0]   ngrids;
  logic              frame_end;
  logic              key_phase;

  assign key_phase = (phase == PH_KEY);
  assign mem_raddr = (phase == PH_DISP) ? idx : '0;

  vfd_scan_seq #(.GAP_TICKS(GAP_TICKS), .DIM_STEP(DIM_STEP), .KEY_TICKS(KEY_TICKS)) seq_i (
    .clk(clk), .rst(rst), .duty_code(duty_code), .phase(phase), .idx(idx),
    .tick(tick), .ngrids(ngrids), .frame_end(frame_end)
  );

  vfd_scan_drive #(.GAP_TICKS(GAP_TICKS), .DIM_STEP(DIM_STEP), .TW(TW)) drive_i (
    .clk(clk), .rst(rst), .phase(phase), .idx(idx), .tick(tick), .ngrids(ngrids),
    .dim_lvl(dim_lvl), .disp_on(disp_on), .word(mem_rdata),
    .seg_lo(seg_lo), .grid_lo(grid_lo), .shared(shared)
  );

  vfd_key_sampler #(.KEY_TICKS(KEY_TICKS), .TW(TW)) keys_i (
    .clk(clk), .rst(rst), .phase(phase), .idx(idx), .tick(tick),
    .frame_end(frame_end), .key_ret(key_ret), .sw_in(sw_in),
    .key_data(key_data), .sw_latch(sw_latch)
  );
endmodule

// File: rtl/vfd_scan_checker.sv
module vfd_scan_checker (
  input logic        clk,
  input logic        rst,
  input logic        disp_on,
  input logic        key_phase,
  input logic        frame_end,
  input logic [11:0] seg_lo,
  input logic [7:0]  grid_lo,
  input logic [7:0]  shared,
  input logic [3:0]  sw_latch
);
  a_r3_one_grid: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grid_lo));

  a_r7_off_blank: assert property (@(posedge clk) disable iff (rst)
    (!disp_on && !key_phase) |=> (grid_lo == '0 && shared == '0 && seg_lo == '0));

  a_r8_key_onehot: assert property (@(posedge clk) disable iff (rst)
    key_phase |=> $onehot(seg_lo));

  a_r8_key_no_grid: assert property (@(posedge clk) disable iff (rst)
    key_phase |=> (grid_lo == '0 && shared == '0));

  a_r10_sw_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(sw_latch));
endmodule

bind vfd_scan_timer vfd_scan_checker chk_i (
  .clk(clk), .rst(rst), .disp_on(disp_on), .key_phase(key_phase),
  .frame_end(frame_end), .seg_lo(seg_lo), .grid_lo(grid_lo),
  .shared(shared), .sw_latch(sw_latch)
);

// File: tb/vfd_scan_timer_tb.sv
`timescale 1ns/1ps
module vfd_scan_timer_tb_top;
  localparam int GAP  = 2;
  localparam int STEP = 2;
  localparam int KT   = 4;
  localparam int SLOT = GAP + 8 * STEP;
  localparam real CLKP = 8.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  duty_code = '0;
  logic [2:0]  dim_lvl = '0;
  logic        disp_on = 1'b0;
  logic [3:0]  mem_raddr;
  logic [19:0] mem_rdata = '0;
  logic [3:0]  key_ret;
  logic [3:0]  sw_in = '0;
  logic [11:0] seg_lo;
  logic [7:0]  grid_lo;
  logic [7:0]  shared;
  logic [47:0] key_data;
  logic [3:0]  sw_latch;

  logic [19:0] mem [16];
  logic [3:0]  keymat [12];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLKP/2) clk = ~clk;

  vfd_scan_timer #(.GAP_TICKS(GAP), .DIM_STEP(STEP), .KEY_TICKS(KT)) dut_i (
    .clk(clk), .rst(rst), .duty_code(duty_code), .dim_lvl(dim_lvl), .disp_on(disp_on),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .key_ret(key_ret), .sw_in(sw_in),
    .seg_lo(seg_lo), .grid_lo(grid_lo), .shared(shared), .key_data(key_data),
    .sw_latch(sw_latch)
  );

  always @(posedge clk) mem_rdata <= mem[mem_raddr];

  always_comb begin
    key_ret = '0;
    for (int s = 0; s < 12; s++)
      if (seg_lo[s]) key_ret = key_ret | keymat[s];
  end

  function automatic int grid_count(input logic [3:0] c);
    return (c > 8) ? 16 : 8 + int'(c);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_pos(input int p, input int ng, input int dim, input bit on,
                           input logic [3:0] swa, input logic [3:0] swb);
    int f, q, g, t, s;
    logic [11:0] es;
    logic [7:0]  eg, eh;
    string tag;
    f  = ng * SLOT + 12 * KT;
    q  = p % f;
    es = '0; eg = '0; eh = '0;
    if (q < ng * SLOT) begin
      g = q / SLOT;
      t = q % SLOT;
      if (!on)                         tag = "R7";
      else if (t < GAP)                tag = "R5";
      else if (t >= GAP + (dim+1)*STEP) tag = "R6";
      else begin
        tag = "R3";
        es = mem[g][11:0];
        for (int j = 0; j < 8; j++)
          if (15 - j >= ng) eh[j] = mem[g][12+j];
        if (g < 8) eg[g] = 1'b1;
        else eh[15-g] = 1'b1;
      end
    end else begin
      tag = "R8";
      s = (q - ng * SLOT) / KT;
      es[s] = 1'b1;
    end
    check({tag, " R2 seg/grid"}, {44'd0, es, eg}, {44'd0, seg_lo, grid_lo});
    check({tag, " R4 shared"}, 64'(eh), 64'(shared));
    if (p < f - 1)          check("R10 sw before capture", 64'(sw_latch), 64'd0);
    else if (p < 2 * f - 1) check("R10 sw first frame", 64'(sw_latch), 64'(swa));
    else                    check("R10 sw second frame", 64'(sw_latch), 64'(swb));
  endtask

  task automatic run(input logic [3:0] code, input int dim, input bit on);
    int ng, f;
    logic [3:0] swa, swb;
    ng = grid_count(code);
    f  = ng * SLOT + 12 * KT;
    for (int i = 0; i < 16; i++) mem[i] = 20'($urandom);
    for (int s = 0; s < 12; s++) keymat[s] = 4'($urandom);
    swa = 4'($urandom);
    swb = ~swa;
    @(negedge clk);
    rst = 1'b1;
    duty_code = code;
    dim_lvl = 3'(dim);
    disp_on = on;
    sw_in = swa;
    repeat (3) @(negedge clk);
    check("R1 reset outputs",
          {seg_lo, grid_lo, shared, sw_latch, mem_raddr}, 64'd0);
    check("R1 reset key map", 64'(key_data), 64'd0);
    rst = 1'b0;
    for (int p = 0; p < 2 * f; p++) begin
      @(posedge clk);
      #2;
      check_pos(p, ng, dim, on, swa, swb);
      if (p == f + 5) sw_in = swb;
    end
    for (int s = 0; s < 12; s++)
      check($sformatf("R9 key source %0d", s), 64'(key_data[s*4 +: 4]), 64'(keymat[s]));
  endtask

  initial begin
    void'($urandom(32'd20515));
    for (int i = 0; i < 16; i++) mem[i] = '0;
    for (int s = 0; s < 12; s++) keymat[s] = '0;
    run(4'd0, 7, 1'b1);
    run(4'd8, 3, 1'b1);
    run(4'd4, 0, 1'b1);
    run(4'd15, 5, 1'b1);
    run(4'd2, 7, 1'b0);
    for (int k = 0; k < 3; k++)
      run(4'($urandom_range(0, 15)), $urandom_range(0, 7), 1'b1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLKP * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule